// File: doc/BRIEF.md
# Single to Half Precision Float Narrowing Converter

This block converts a 32-bit single-precision floating-point word into a 16-bit half-precision word, together with the four exception flags that the conversion can produce. Each valid input is converted independently. The result appears a fixed number of clock cycles later. There are four rounding directions, selected per input. A per-input format bit chooses between IEEE half precision and an alternative half format. The alternative format has no infinity or NaN codes and uses exponent field 31 as ordinary numbers.

The datapath works as follows. It finds the unbiased exponent of the input and chooses how many low significand bits to discard. This count grows by one for each step the value lies below the smallest half normal. It then rounds the kept bits and folds any carry out of rounding back into the exponent. After rounding it either packs a normal number, packs a subnormal, flushes to a signed zero, or saturates on overflow. The `STAGES` parameter selects whether there is one register stage or two. `TINY_BEFORE` selects when underflow is detected: before rounding or after it.

Top module: `f32_to_f16_narrow`

## Requirements
- R1: After reset, `out_valid`, `out_data` and all flags are 0. Each accepted input (`in_valid`=1) produces exactly one `out_valid` pulse `STAGES` cycles later, and results come out in input order.
- R2: An input with exponent field 255 gives exponent field 31 and fraction input[22:13], in both formats. For a NaN, result bit 9 is forced to 1. `flag_invalid` is raised only when the input NaN had bit 22 clear. Infinity raises no flag.
- R3: +0 and −0 give 0x0000 and 0x8000 respectively, with no flag raised.
- R4: `rnd_mode`=0 rounds to nearest. On an exact tie, the kept value rounds up only if its lowest bit is 1.
- R5: `rnd_mode`=1 rounds toward +infinity and `rnd_mode`=2 rounds toward −infinity: the magnitude is incremented when any discarded bit is set and the sign matches the direction. `rnd_mode`=3 truncates.
- R6: When rounding carries the significand to 2.0, the exponent rises by one and the fraction becomes 0. For example, 0x3FFFF000 rounded to nearest gives 0x4000.
- R7: With `alt_fmt`=0, a rounded exponent above 15 gives signed infinity (0x7C00 or 0xFC00) and raises `flag_overflow` and `flag_inexact`, in every rounding mode.
- R8: With `alt_fmt`=1, exponent 16 encodes normally as field 31. A rounded exponent above 16 gives the signed largest magnitude (0x7FFF or 0xFFFF) and raises `flag_overflow` and `flag_inexact`.
- R9: Values with an unbiased exponent from −24 to −15 give exponent field 0 and a fraction aligned to 2^-24. If rounding reaches 2^-14, the result is field 1 with fraction 0.
- R10: Values below 2^-24, including single-precision subnormals, discard every significand bit. The result is a signed zero or ±0x0001, as the rounding mode decides.
- R11: `flag_inexact` is raised exactly when a discarded bit is nonzero or overflow occurs.
- R12: With `TINY_BEFORE`=1, `flag_underflow` is raised for every nonzero finite input whose exponent is below −14, even when the result is exact. With `TINY_BEFORE`=0, it is raised only when the result has exponent field 0 and is inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 32 | Single-precision operand |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward +inf, 2 toward −inf, 3 toward zero |
| alt_fmt | input | 1 | 0 IEEE half, 1 alternative half without infinity/NaN |
| out_valid | output | 1 | Result is valid |
| out_data | output | 16 | Half-precision result |
| flag_invalid | output | 1 | Signalling NaN input |
| flag_overflow | output | 1 | Result exceeded the format range |
| flag_underflow | output | 1 | Tiny result, per `TINY_BEFORE` |
| flag_inexact | output | 1 | Result differs from the input value |

## Verification
The bench builds two instances side by side. The first uses `STAGES`=2 and `TINY_BEFORE`=1. The second uses `STAGES`=1 and `TINY_BEFORE`=0. Both latencies are therefore checked, and so are both underflow rules. Two inputs show the difference between the rules: an exact 2^-15, and a value that rounds up to the smallest normal. Each instance gets the same directed corner values and a biased random stream, in both formats and all four rounding modes.

// File: rtl/f32_to_f16_narrow.sv
module f32_to_f16_narrow #(
  parameter int STAGES      = 2,
  parameter bit TINY_BEFORE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic [1:0]  rnd_mode,
  input  logic        alt_fmt,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic        flag_invalid,
  output logic        flag_overflow,
  output logic        flag_underflow,
  output logic        flag_inexact
);

  logic        v_a;
  logic [31:0] d_a;
  logic [1:0]  m_a;
  logic        alt_a;

  generate
    if (STAGES == 2) begin : g_in_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          v_a <= 1'b0; d_a <= '0; m_a <= '0; alt_a <= 1'b0;
        end else begin
          v_a <= in_valid; d_a <= in_data; m_a <= rnd_mode; alt_a <= alt_fmt;
        end
    end else begin : g_in_wire
      assign v_a   = in_valid;
      assign d_a   = in_data;
      assign m_a   = rnd_mode;
      assign alt_a = alt_fmt;
    end
  endgenerate

  wire        sgn     = d_a[31];
  wire [7:0]  ex      = d_a[30:23];
  wire [22:0] fr      = d_a[22:0];
  wire        is_spec = (ex == 8'hff);
  wire        is_zero = (ex == 8'h00) && (fr == '0);
  wire [23:0] sig     = {ex != 8'h00, fr};

  logic signed [9:0] ue, below;
  logic        normal;
  logic [3:0]  d;
  assign ue     = (ex == 8'h00) ? -10'sd126 : $signed({2'b00, ex}) - 10'sd127;
  assign normal = (ue >= -10'sd14);
  assign below  = -10'sd14 - ue;

  always_comb begin
    if (normal)              d = 4'd0;
    else if (below > 10'sd12) d = 4'd12;
    else                     d = below[3:0];
  end

  // discarded bits sit in w[25:0]; shifts of up to 12 drop only the zero pad
  wire [36:0] w      = {sig, 13'b0} >> d;
  wire [10:0] kept   = w[36:26];
  wire        guard  = w[25];
  wire        sticky = |w[24:0];
  wire        inex   = guard | sticky;

  logic inc;
  always_comb begin
    case (m_a)
      2'd0:    inc = guard & (sticky | kept[0]);
      2'd1:    inc = inex & ~sgn;
      2'd2:    inc = inex & sgn;
      default: inc = 1'b0;
    endcase
  end

  wire [11:0] rnd   = {1'b0, kept} + {11'b0, inc};
  wire [7:0]  ebias = ue[7:0] + 8'd14;
  wire [17:0] mag   = (normal ? {ebias, 10'b0} : 18'b0) + {6'b0, rnd};
  wire        ovf   = !is_spec && (alt_a ? (mag >= 18'h08000) : (mag >= 18'h07c00));
  wire        tiny  = TINY_BEFORE ? (!normal && !is_zero)
                                  : ((mag < 18'h00400) && inex);

  logic [15:0] res;
  logic [3:0]  flg;
  always_comb begin
    if (is_spec) begin
      res = {sgn, 5'h1f, fr[22] | (fr != '0), fr[21:13]};
      flg = {(fr != '0) && !fr[22], 3'b000};
    end else if (ovf) begin
      res = {sgn, alt_a ? 15'h7fff : 15'h7c00};
      flg = 4'b0101;
    end else begin
      res = {sgn, mag[14:0]};
      flg = {2'b00, tiny, inex};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      {flag_invalid, flag_overflow, flag_underflow, flag_inexact} <= '0;
    end else begin
      out_valid <= v_a;
      out_data  <= v_a ? res : 16'h0000;
      {flag_invalid, flag_overflow, flag_underflow, flag_inexact} <= v_a ? flg : 4'b0000;
    end

  a_r1_one_result_per_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(v_a));

  a_r2_invalid_is_quiet_nan: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> (out_data[14:10] == 5'h1f) && out_data[9] && !flag_overflow);

  a_r7_overflow_is_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> flag_inexact);

  a_r8_overflow_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> (out_data[14:10] == 5'h1f) &&
                      ((out_data[9:0] == 10'h000) || (out_data[9:0] == 10'h3ff)));

  a_r12_underflow_is_tiny: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> (out_data[14:10] <= 5'd1) && !flag_overflow);

  a_r11_idle_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == 16'h0000) && !flag_inexact && !flag_invalid);

endmodule

// File: tb/test_f32_to_f16_narrow.sv
`timescale 1ns/1ps
module test_f32_to_f16_narrow;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0]  rnd_mode = '0;
  logic        alt_fmt = 1'b0;

  logic        ov0, ov1;
  logic [15:0] od0, od1;
  logic        fi0, fo0, fu0, fx0, fi1, fo1, fu1, fx1;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic [19:0] q0[$], q1[$];
  string       t0[$], t1[$];
  int          c0[$], c1[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  f32_to_f16_narrow #(.STAGES(2), .TINY_BEFORE(1'b1)) i_f32_to_f16_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rnd_mode(rnd_mode), .alt_fmt(alt_fmt), .out_valid(ov0), .out_data(od0),
    .flag_invalid(fi0), .flag_overflow(fo0), .flag_underflow(fu0), .flag_inexact(fx0));

  f32_to_f16_narrow #(.STAGES(1), .TINY_BEFORE(1'b0)) i_f32_to_f16_narrow_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rnd_mode(rnd_mode), .alt_fmt(alt_fmt), .out_valid(ov1), .out_data(od1),
    .flag_invalid(fi1), .flag_overflow(fo1), .flag_underflow(fu1), .flag_inexact(fx1));

  // reference: returns {half, invalid, overflow, underflow, inexact}
  function automatic logic [19:0] model(logic [31:0] a, logic [1:0] m, bit alt, bit tb4);
    int s, e, ue, E, k, field;
    longint sig, n, r, half;
    bit inex, up, uf;
    s = a[31]; e = a[30:23];
    if (e == 255) begin
      if (a[22:0] == 0) return {s[0], 5'h1f, 10'h000, 4'b0000};
      return {s[0], 5'h1f, 1'b1, a[21:13], (a[22] == 1'b0), 3'b000};
    end
    if (e == 0 && a[22:0] == 0) return {s[0], 15'h0000, 4'b0000};
    if (e == 0) begin sig = a[22:0]; ue = -126; end
    else begin sig = a[22:0] + 64'd8388608; ue = e - 127; end
    E = (ue < -14) ? -14 : ue;
    k = E - ue + 13;
    if (k > 26) k = 26;
    n = sig >> k;
    r = sig - (n << k);
    half = 64'sd1 << (k - 1);
    inex = (r != 0);
    case (m)
      2'd0: up = (r > half) || (r == half && n % 2 == 1);
      2'd1: up = inex && s == 0;
      2'd2: up = inex && s == 1;
      default: up = 0;
    endcase
    n = n + up;
    if (n == 2048) begin n = 1024; E = E + 1; end
    if ((!alt && E > 15) || (alt && E > 16))
      return {s[0], alt ? 15'h7fff : 15'h7c00, 4'b0101};
    if (n >= 1024) field = E + 15; else field = 0;
    if (n >= 1024) n = n - 1024;
    uf = tb4 ? (ue < -14) : (field == 0 && inex);
    return {s[0], field[4:0], n[9:0], 1'b0, 1'b0, uf, inex};
  endfunction

  function automatic string tag_of(logic [31:0] a);
    int e; e = a[30:23];
    if (e == 255) return "R2";
    if (a[30:0] == 0) return "R3";
    if (e < 103) return "R10";
    if (e < 113) return "R9";
    if (e > 142) return "R7";
    return "R4";
  endfunction

  task automatic send(logic [31:0] a, logic [1:0] m, bit alt, string tag);
    @(posedge clk); #2;
    in_valid = 1'b1; in_data = a; rnd_mode = m; alt_fmt = alt;
    q0.push_back(model(a, m, alt, 1'b1)); t0.push_back(tag); c0.push_back(cyc + 2);
    q1.push_back(model(a, m, alt, 1'b0)); t1.push_back(tag); c1.push_back(cyc + 1);
  endtask

  task automatic idle();
    @(posedge clk); #2;
    in_valid = 1'b0; in_data = '0;
  endtask

  task automatic judge(string who, string tag, logic [19:0] got, logic [19:0] exp, int gc, int ec);
    checks++;
    if (got !== exp || gc != ec) begin
      fails++;
      $display("FAIL %s %s: got %h @%0d expected %h @%0d", tag, who, got, gc, exp, ec);
    end
  endtask

  always @(negedge clk) if (rst_n && !done && ov0) begin
    if (q0.size() == 0) begin
      checks++; fails++;
      $display("FAIL R1 dut0: got unexpected out_valid expected none");
    end else
      judge("dut0", t0.pop_front(), {od0, fi0, fo0, fu0, fx0}, q0.pop_front(), cyc, c0.pop_front());
  end

  always @(negedge clk) if (rst_n && !done && ov1) begin
    if (q1.size() == 0) begin
      checks++; fails++;
      $display("FAIL R1 dut1: got unexpected out_valid expected none");
    end else
      judge("dut1", t1.pop_front(), {od1, fi1, fo1, fu1, fx1}, q1.pop_front(), cyc, c1.pop_front());
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state of both instances
    checks++;
    if ({ov0, od0, fi0, fo0, fu0, fx0, ov1, od1, fi1, fo1, fu1, fx1} !== '0) begin
      fails++;
      $display("FAIL R1 reset: got %h/%h expected 0", od0, od1);
    end
    #3 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    send(32'h3f800000, 0, 0, "R4");   // 1.0
    send(32'h3f801000, 0, 0, "R4");   // tie, even kept -> down
    send(32'h3f803000, 0, 0, "R4");   // tie, odd kept -> up
    send(32'hbf801800, 0, 0, "R4");
    send(32'h3f800001, 1, 0, "R5");
    send(32'hbf800001, 1, 0, "R5");
    send(32'h3f800001, 2, 0, "R5");
    send(32'hbf800001, 2, 0, "R5");
    send(32'hbf801fff, 3, 0, "R5");
    send(32'h3ffff000, 0, 0, "R6");
    send(32'h3f7ff000, 0, 0, "R6");
    send(32'h7fc00000, 0, 0, "R2");
    send(32'h7f800001, 0, 0, "R2");
    send(32'hff812345, 3, 1, "R2");
    send(32'hff800000, 0, 0, "R2");
    send(32'h7f800000, 0, 1, "R2");
    send(32'h00000000, 1, 0, "R3");
    send(32'h80000000, 2, 1, "R3");
    send(32'h477fe000, 0, 0, "R7");
    send(32'h477ff000, 0, 0, "R7");
    send(32'hc8000000, 3, 0, "R7");
    send(32'h477ff000, 0, 1, "R8");
    send(32'h47800000, 0, 1, "R8");
    send(32'h47ffe000, 3, 1, "R8");
    send(32'hc7fff000, 0, 1, "R8");
    send(32'h7f000000, 1, 1, "R8");
    send(32'h38000000, 0, 0, "R12");  // exact 2^-15
    send(32'h387ff000, 0, 0, "R12");  // rounds to smallest normal
    send(32'h33800000, 0, 0, "R9");
    send(32'h38555555, 0, 0, "R9");
    send(32'hb7abcdef, 1, 0, "R9");
    send(32'h33000000, 0, 0, "R10");  // half of smallest subnormal, tie
    send(32'h33400000, 0, 0, "R10");
    send(32'h33000000, 1, 0, "R10");
    send(32'h00000001, 1, 0, "R10");
    send(32'h80000001, 2, 1, "R10");
    send(32'h80000001, 0, 0, "R10");
    send(32'h3f800000, 3, 1, "R11");
    send(32'h3f800fff, 3, 1, "R11");
    idle(); idle(); idle();
    send(32'h40490fdb, 0, 0, "R1");
    idle();
    send(32'h40490fdb, 2, 1, "R1");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = $urandom;
      if (i % 3 != 0) a[30:23] = 8'd96 + 8'($urandom % 56);
      if (i % 7 == 0) idle();
      send(a, 2'($urandom), 1'($urandom), tag_of(a));
    end
    idle();
    repeat (6) @(posedge clk);
    checks++;
    if (q0.size() != 0 || q1.size() != 0) begin
      fails++;
      $display("FAIL R1 drain: got %0d/%0d pending expected 0", q0.size(), q1.size());
    end
    finish_run();
  end
endmodule